// File: doc/BRIEF.md
# Slow-Control Common Register Bank

This block answers a simple 32-bit slow-control bus: an address, write data, a read strobe and a write strobe in, and a registered reply one clock later carrying read data and one of three outcomes (acknowledge, unknown address, or refused write). Behind the bus are two read-only status words, a pulse register, two hold registers, a pair of 16-bit trigger counters and a small constant store of board facts.

The pulse register turns software writes into single-cycle strobes. These strobes drive four user-logic resets, a sequence-counter reset, a reboot request, sixteen test triggers and the clearing of each trigger counter. The first hold register also preloads the level-1 counter, and this is the preferred way to set it. The board-information store holds 16-bit words and returns them two at a time, so each 32-bit read carries one pair.

Top module: `ctrl_stat_bank`

## Requirements
- R1: A write to address 0x20 sets the pulse register for exactly one clock cycle, and it returns to all zeros on the next cycle unless 0x20 is written again. A read of 0x20 returns zero.
- R2: Pulse bit mapping at 0x20: bits 3:0 drive `user_rst_o[3:0]`, bit 10 drives `seq_rst_o`, bit 15 drives `reboot_o`, and bit 16+n drives `test_trig_o[n]` for n from 0 to 15. The other bits reach no output port.
- R3: Addresses 0x21 and 0x22 hold the last value written to them. The held value appears on `ctrl1_o` and `ctrl2_o` and is returned when the address is read.
- R4: A write to 0x21 loads its data bits 15:0 into the level-1 trigger counter.
- R5: Pulse bit 8 clears the level-1 counter and pulse bit 9 clears the level-2 counter. The clear takes effect on the clock edge at which the pulse is high.
- R6: Each counter adds one on every clock edge at which its trigger input is high, and wraps from 0xFFFF to 0. A clear or preload on the same edge wins over the trigger.
- R7: A read of 0x01 returns the level-1 counter in bits 15:0 and the level-2 counter in bits 31:16.
- R8: A read of 0x00 returns `err_flags_i[5:0]` in bits 5:0, zeros in bits 19:6, and `temp_i[11:0]` in bits 31:20.
- R9: Reads of 0x40 to 0x43 return the information-word pair (2n, 2n+1), with word 2n in bits 15:0. With the parameters used here: 0x40 = BUILD_TIME, 0x41 = {16'h0, VERSION}, 0x42 = HW_INFO, 0x43 = 0.
- R10: Each access gets a one-cycle reply on the following clock, and exactly one of `bus_ack`, `bus_unknown`, `bus_err` is set. Unmapped addresses give `bus_unknown`. A write to a read-only address (0x00, 0x01, 0x40 to 0x43) gives `bus_err` and changes nothing. Idle cycles give no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (wins over a read in the same cycle) |
| bus_rdata | output | 32 | Read data, valid with the reply |
| bus_ack | output | 1 | Access accepted |
| bus_unknown | output | 1 | Address not mapped |
| bus_err | output | 1 | Write to a read-only address refused |
| err_flags_i | input | 6 | Severity flags and two counter-mismatch flags |
| temp_i | input | 12 | Temperature, low 4 bits fractional |
| lvl1_trig_i | input | 1 | Level-1 trigger pulse |
| lvl2_trig_i | input | 1 | Level-2 trigger pulse |
| user_rst_o | output | 4 | User-logic reset pulses |
| seq_rst_o | output | 1 | Sequence-counter reset pulse |
| reboot_o | output | 1 | Reboot request pulse |
| test_trig_o | output | 16 | Test-trigger pulses |
| ctrl1_o | output | 32 | Held control word at 0x21 |
| ctrl2_o | output | 32 | Held control word at 0x22 |

## Verification
Every single-bit value is written to the pulse register, and then dense and alternating patterns. Single bits show whether a bit is routed to the wrong output. Multi-bit words and back-to-back writes show whether the pulse stretches or merges across cycles. The counters are driven with bursts of growing length and are also pushed across the 16-bit wrap, which separates off-by-one errors from errors in wrap handling. A trigger is applied on the same edge as a clear or a preload to test the priority. All 64 flag values are swept with varying temperatures to check the field positions in the status word. Every one of the 256 addresses is read to check the decode, and refused writes are followed by read-back to show that nothing changed.

// File: rtl/csb_pkg.sv
package csb_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = DATA_W / 2;
  localparam int FLAG_W  = 6;
  localparam int TEMP_W  = 12;
  localparam int INFO_WW = 16;
  localparam int INFO_WORDS = 8;
  localparam int INFO_REGS  = INFO_WORDS / 2;

  localparam int STAT0_ADDR  = 'h00;
  localparam int STAT1_ADDR  = 'h01;
  localparam int STROBE_ADDR = 'h20;
  localparam int CTRL1_ADDR  = 'h21;
  localparam int CTRL2_ADDR  = 'h22;
  localparam int INFO_BASE   = 'h40;

  localparam int PB_USER_LO = 0;
  localparam int PB_USER_N  = 4;
  localparam int PB_L1_CLR  = 8;
  localparam int PB_L2_CLR  = 9;
  localparam int PB_SEQ     = 10;
  localparam int PB_REBOOT  = 15;
  localparam int PB_TRIG_LO = 16;
  localparam int PB_TRIG_N  = 16;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STAT0, SEL_STAT1, SEL_STROBE, SEL_CTRL1, SEL_CTRL2, SEL_INFO
  } reg_sel_e;

  function automatic reg_sel_e csb_decode(input logic [31:0] a);
    if (a == STAT0_ADDR)       return SEL_STAT0;
    else if (a == STAT1_ADDR)  return SEL_STAT1;
    else if (a == STROBE_ADDR) return SEL_STROBE;
    else if (a == CTRL1_ADDR)  return SEL_CTRL1;
    else if (a == CTRL2_ADDR)  return SEL_CTRL2;
    else if (a >= INFO_BASE && a < INFO_BASE + INFO_REGS) return SEL_INFO;
    else return SEL_NONE;
  endfunction

  function automatic logic sel_writable(input reg_sel_e s);
    return (s == SEL_STROBE) || (s == SEL_CTRL1) || (s == SEL_CTRL2);
  endfunction

  function automatic logic [DATA_W-1:0] pack_status0(
      input logic [FLAG_W-1:0] flags, input logic [TEMP_W-1:0] temp);
    return {temp, {(DATA_W-TEMP_W-FLAG_W){1'b0}}, flags};
  endfunction
endpackage

// File: rtl/csb_strobe_reg.sv
module csb_strobe_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pulse_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pulse_q <= '0;
    else if (wr_en) pulse_q <= wdata;
    else            pulse_q <= '0;
  end
endmodule

// File: rtl/csb_trig_counter.sv
module csb_trig_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] count
);
  function automatic logic [W-1:0] next_count(
      input logic [W-1:0] cur, input logic c, input logic l,
      input logic [W-1:0] lv, input logic i);
    if (c)      return '0;
    else if (l) return lv;
    else if (i) return cur + W'(1);
    else        return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(count, clr, load, load_val, inc);
  end
endmodule

// File: rtl/csb_info_store.sv
module csb_info_store #(
  parameter int WW    = 16,
  parameter int WORDS = 8,
  parameter logic [WORDS*WW-1:0] INIT = '0,
  localparam int REGS  = WORDS / 2,
  localparam int IDX_W = (REGS > 1) ? $clog2(REGS) : 1
) (
  input  logic [IDX_W-1:0] sel,
  output logic [2*WW-1:0]  pair
);
  logic [2*WW-1:0] pairs [REGS];

  for (genvar n = 0; n < REGS; n++) begin : g_pair
    assign pairs[n] = INIT[2*n*WW +: 2*WW];
  end

  assign pair = pairs[sel];
endmodule

// File: rtl/ctrl_stat_bank.sv
module ctrl_stat_bank
  import csb_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter logic [31:0] BUILD_TIME = 32'h0,
  parameter logic [15:0] VERSION    = 16'h0,
  parameter logic [31:0] HW_INFO    = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [31:0]       bus_rdata,
  output logic              bus_ack,
  output logic              bus_unknown,
  output logic              bus_err,
  input  logic [5:0]        err_flags_i,
  input  logic [11:0]       temp_i,
  input  logic              lvl1_trig_i,
  input  logic              lvl2_trig_i,
  output logic [3:0]        user_rst_o,
  output logic              seq_rst_o,
  output logic              reboot_o,
  output logic [15:0]       test_trig_o,
  output logic [31:0]       ctrl1_o,
  output logic [31:0]       ctrl2_o
);
  localparam int INFO_IDX_W = (INFO_REGS > 1) ? $clog2(INFO_REGS) : 1;
  localparam int NUM_CNT = 2;
  localparam logic [INFO_WORDS*INFO_WW-1:0] INFO_INIT =
    {{(INFO_WORDS*INFO_WW-96){1'b0}}, HW_INFO, 16'h0, VERSION, BUILD_TIME};

  // Decode
  reg_sel_e sel;
  logic     access, is_write, is_read;
  assign sel      = csb_decode(32'(bus_addr));
  assign is_write = bus_wr;
  assign is_read  = bus_rd & ~bus_wr;
  assign access   = bus_rd | bus_wr;

  // Named events brought out for the checker
  logic strobe_wr_ev, ctrl1_wr_ev, ctrl2_wr_ev;
  assign strobe_wr_ev = is_write && (sel == SEL_STROBE);
  assign ctrl1_wr_ev  = is_write && (sel == SEL_CTRL1);
  assign ctrl2_wr_ev  = is_write && (sel == SEL_CTRL2);

  // Pulse register
  logic [DATA_W-1:0] strobe_q;
  csb_strobe_reg #(.W(DATA_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .wr_en(strobe_wr_ev),
    .wdata(bus_wdata), .pulse_q(strobe_q)
  );

  assign user_rst_o  = strobe_q[PB_USER_LO +: PB_USER_N];
  assign seq_rst_o   = strobe_q[PB_SEQ];
  assign reboot_o    = strobe_q[PB_REBOOT];
  assign test_trig_o = strobe_q[PB_TRIG_LO +: PB_TRIG_N];

  // Hold registers
  logic [DATA_W-1:0] ctrl1_q, ctrl2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl1_q <= '0;
      ctrl2_q <= '0;
    end else begin
      if (ctrl1_wr_ev) ctrl1_q <= bus_wdata;
      if (ctrl2_wr_ev) ctrl2_q <= bus_wdata;
    end
  end
  assign ctrl1_o = ctrl1_q;
  assign ctrl2_o = ctrl2_q;

  // Trigger counters: index 0 is level 1, index 1 is level 2
  logic             cnt_clr  [NUM_CNT];
  logic             cnt_load [NUM_CNT];
  logic             cnt_inc  [NUM_CNT];
  logic [CNT_W-1:0] cnt_lval [NUM_CNT];
  logic [CNT_W-1:0] cnt_q    [NUM_CNT];

  assign cnt_clr[0]  = strobe_q[PB_L1_CLR];
  assign cnt_load[0] = ctrl1_wr_ev;
  assign cnt_lval[0] = bus_wdata[CNT_W-1:0];
  assign cnt_inc[0]  = lvl1_trig_i;
  assign cnt_clr[1]  = strobe_q[PB_L2_CLR];
  assign cnt_load[1] = 1'b0;
  assign cnt_lval[1] = '0;
  assign cnt_inc[1]  = lvl2_trig_i;

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    csb_trig_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr[k]), .load(cnt_load[k]),
      .load_val(cnt_lval[k]), .inc(cnt_inc[k]), .count(cnt_q[k])
    );
  end

  logic [CNT_W-1:0] lvl1_count;
  logic             lvl1_clr_ev, lvl1_load_ev;
  assign lvl1_count   = cnt_q[0];
  assign lvl1_clr_ev  = cnt_clr[0];
  assign lvl1_load_ev = cnt_load[0];

  // Information store (base is aligned, so low address bits index it)
  logic [DATA_W-1:0] info_pair;
  csb_info_store #(.WW(INFO_WW), .WORDS(INFO_WORDS), .INIT(INFO_INIT)) u_info (
    .sel(bus_addr[INFO_IDX_W-1:0]), .pair(info_pair)
  );

  // Read mux
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    unique case (sel)
      SEL_STAT0:  rd_mux = pack_status0(err_flags_i, temp_i);
      SEL_STAT1:  rd_mux = {cnt_q[1], cnt_q[0]};
      SEL_CTRL1:  rd_mux = ctrl1_q;
      SEL_CTRL2:  rd_mux = ctrl2_q;
      SEL_INFO:   rd_mux = info_pair;
      default:    rd_mux = '0;
    endcase
  end

  // Registered reply
  logic mapped, writable;
  assign mapped   = (sel != SEL_NONE);
  assign writable = sel_writable(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata   <= '0;
      bus_ack     <= 1'b0;
      bus_unknown <= 1'b0;
      bus_err     <= 1'b0;
    end else begin
      bus_ack     <= access && mapped && (!is_write || writable);
      bus_unknown <= access && !mapped;
      bus_err     <= is_write && mapped && !writable;
      bus_rdata   <= (is_read && mapped) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/csb_checker.sv
module csb_checker #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              bus_ack,
  input logic              bus_unknown,
  input logic              bus_err,
  input logic [3:0]        user_rst_o,
  input logic              seq_rst_o,
  input logic              reboot_o,
  input logic [15:0]       test_trig_o,
  input logic [31:0]       ctrl1_o,
  input logic              lvl1_trig_i,
  input logic [31:0]       strobe_q,
  input logic [CNT_W-1:0]  lvl1_count,
  input logic              lvl1_clr_ev,
  input logic              lvl1_load_ev
);
  logic pulse_wr, ctrl1_wr, any_pulse;
  assign pulse_wr  = bus_wr && (bus_addr == ADDR_W'(csb_pkg::STROBE_ADDR));
  assign ctrl1_wr  = bus_wr && (bus_addr == ADDR_W'(csb_pkg::CTRL1_ADDR));
  assign any_pulse = (|user_rst_o) | seq_rst_o | reboot_o | (|test_trig_o);

  a_r1_pulse_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_wr |=> (strobe_q == 32'h0) && !any_pulse);

  a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl1_wr |=> $stable(ctrl1_o));

  a_r4_preload: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl1_load_ev && !lvl1_clr_ev) |=> lvl1_count == $past(bus_wdata[CNT_W-1:0]));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    lvl1_clr_ev |=> lvl1_count == '0);

  a_r6_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl1_trig_i && !lvl1_clr_ev && !lvl1_load_ev)
      |=> lvl1_count == CNT_W'($past(lvl1_count) + CNT_W'(1)));

  a_r10_one_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |=> $countones({bus_ack, bus_unknown, bus_err}) == 1);

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |=> !(bus_ack || bus_unknown || bus_err));
endmodule

bind ctrl_stat_bank csb_checker #(.ADDR_W(ADDR_W), .CNT_W(csb_pkg::CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_unknown(bus_unknown), .bus_err(bus_err),
  .user_rst_o(user_rst_o), .seq_rst_o(seq_rst_o), .reboot_o(reboot_o),
  .test_trig_o(test_trig_o), .ctrl1_o(ctrl1_o), .lvl1_trig_i(lvl1_trig_i),
  .strobe_q(strobe_q), .lvl1_count(lvl1_count), .lvl1_clr_ev(lvl1_clr_ev),
  .lvl1_load_ev(lvl1_load_ev)
);

// File: tb/ctrl_stat_bank_test.sv
module ctrl_stat_bank_test;
  localparam logic [31:0] BT  = 32'h4A6B_1C2D;
  localparam logic [15:0] VER = 16'h0213;
  localparam logic [31:0] HW  = 32'h0055_AA01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_ack, bus_unknown, bus_err;
  logic [5:0]  err_flags_i = '0;
  logic [11:0] temp_i = '0;
  logic        lvl1_trig_i = 1'b0, lvl2_trig_i = 1'b0;
  logic [3:0]  user_rst_o;
  logic        seq_rst_o, reboot_o;
  logic [15:0] test_trig_o;
  logic [31:0] ctrl1_o, ctrl2_o;

  ctrl_stat_bank #(.ADDR_W(8), .BUILD_TIME(BT), .VERSION(VER), .HW_INFO(HW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .bus_unknown(bus_unknown), .bus_err(bus_err), .err_flags_i(err_flags_i),
    .temp_i(temp_i), .lvl1_trig_i(lvl1_trig_i), .lvl2_trig_i(lvl2_trig_i),
    .user_rst_o(user_rst_o), .seq_rst_o(seq_rst_o), .reboot_o(reboot_o),
    .test_trig_o(test_trig_o), .ctrl1_o(ctrl1_o), .ctrl2_o(ctrl2_o)
  );

  always #10 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] r_data;
  logic [2:0]  r_resp;
  logic [21:0] r_pulse;
  logic [15:0] m1 = '0, m2 = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [21:0] pulses_now();
    return {test_trig_o, reboot_o, seq_rst_o, user_rst_o};
  endfunction

  function automatic logic [21:0] pulse_map(input logic [31:0] d);
    return {d[31:16], d[15], d[10], d[3:0]};
  endfunction

  function automatic logic [2:0] exp_resp(input bit w, input logic [7:0] a);
    bit mapped, wrt;
    mapped = (a == 8'h00) || (a == 8'h01) || (a >= 8'h20 && a <= 8'h22) || (a >= 8'h40 && a <= 8'h43);
    wrt = (a >= 8'h20 && a <= 8'h22);
    if (!mapped) return 3'b010;
    if (w && !wrt) return 3'b001;
    return 3'b100;
  endfunction

  // Starts and ends at a falling edge
  task automatic access(input bit w, input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = !w;
    @(posedge clk);
    @(negedge clk);
    r_data = bus_rdata; r_resp = {bus_ack, bus_unknown, bus_err}; r_pulse = pulses_now();
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic burst(input bit l1, input bit l2, input int n);
    lvl1_trig_i = l1; lvl2_trig_i = l2;
    repeat (n) @(negedge clk);
    lvl1_trig_i = 1'b0; lvl2_trig_i = 1'b0;
    if (l1) m1 = m1 + 16'(n);
    if (l2) m2 = m2 + 16'(n);
  endtask

  task automatic read_counts(input string tag);
    access(1'b0, 8'h01, 32'h0);
    check(r_data == {m2, m1} && r_resp == 3'b100, tag, r_data, {m2, m1});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state (R1, R3, R10)
    check(pulses_now() == 22'h0, "R1 reset pulses", 32'(pulses_now()), 0);
    check(ctrl1_o == 0 && ctrl2_o == 0, "R3 reset ctrl", ctrl1_o | ctrl2_o, 0);
    check({bus_ack, bus_unknown, bus_err} == 3'b000, "R10 reset reply", 32'({bus_ack, bus_unknown, bus_err}), 0);

    // Single-bit pulse sweep (R1, R2)
    for (int b = 0; b < 32; b++) begin
      access(1'b1, 8'h20, 32'h1 << b);
      check(r_pulse == pulse_map(32'h1 << b), "R2 bit map", 32'(r_pulse), 32'(pulse_map(32'h1 << b)));
      check(r_resp == 3'b100, "R10 pulse write ack", 32'(r_resp), 32'h4);
      @(negedge clk);
      check(pulses_now() == 22'h0, "R1 self clear", 32'(pulses_now()), 0);
    end
    // Back-to-back multi-bit writes (R1, R2)
    access(1'b1, 8'h20, 32'hFFFF_FFFF);
    check(r_pulse == pulse_map(32'hFFFF_FFFF), "R2 all ones", 32'(r_pulse), 32'(pulse_map(32'hFFFF_FFFF)));
    access(1'b1, 8'h20, 32'hA5A5_5A5A);
    check(r_pulse == pulse_map(32'hA5A5_5A5A), "R1 back to back", 32'(r_pulse), 32'(pulse_map(32'hA5A5_5A5A)));
    @(negedge clk);
    check(pulses_now() == 22'h0, "R1 clear after pair", 32'(pulses_now()), 0);
    access(1'b0, 8'h20, 32'h0);
    check(r_data == 32'h0 && r_resp == 3'b100, "R1 read zero", r_data, 0);
    m1 = '0; m2 = '0;

    // Hold registers and preload (R3, R4, R7)
    access(1'b1, 8'h21, 32'h1234_ABCD);
    m1 = 16'hABCD;
    check(ctrl1_o == 32'h1234_ABCD, "R3 ctrl1 out", ctrl1_o, 32'h1234_ABCD);
    repeat (3) @(negedge clk);
    access(1'b1, 8'h22, 32'h0F0F_7777);
    check(ctrl1_o == 32'h1234_ABCD && ctrl2_o == 32'h0F0F_7777, "R3 hold", ctrl1_o, 32'h1234_ABCD);
    access(1'b0, 8'h21, 32'h0);
    check(r_data == 32'h1234_ABCD, "R3 read ctrl1", r_data, 32'h1234_ABCD);
    access(1'b0, 8'h22, 32'h0);
    check(r_data == 32'h0F0F_7777, "R3 read ctrl2", r_data, 32'h0F0F_7777);
    read_counts("R4 R7 preload");

    // Counting bursts (R6, R7)
    for (int k = 1; k <= 8; k++) begin
      burst(1'b1, (k % 2) == 0, k);
      read_counts("R6 burst count");
    end
    // Level-1 wrap (R6)
    access(1'b1, 8'h21, 32'h0000_FFFE); m1 = 16'hFFFE;
    burst(1'b1, 1'b0, 3);
    read_counts("R6 lvl1 wrap");
    check(m1 == 16'h0001, "R6 wrap model", 32'(m1), 1);
    // Level-2 wrap (R6)
    burst(1'b0, 1'b1, 65536 - int'(m2));
    read_counts("R6 lvl2 wrap");
    burst(1'b0, 1'b1, 2);
    read_counts("R6 after wrap");

    // Preload beats trigger (R6)
    lvl1_trig_i = 1'b1;
    access(1'b1, 8'h21, 32'h0000_0100);
    lvl1_trig_i = 1'b0; m1 = 16'h0100;
    read_counts("R6 preload priority");
    // Clear beats trigger (R5, R6)
    burst(1'b1, 1'b1, 4);
    access(1'b1, 8'h20, 32'h0000_0300);
    lvl1_trig_i = 1'b1; lvl2_trig_i = 1'b1;
    @(negedge clk);
    lvl1_trig_i = 1'b0; lvl2_trig_i = 1'b0;
    m1 = '0; m2 = '0;
    read_counts("R5 clear priority");
    // Clear only level 1 (R5)
    burst(1'b1, 1'b1, 5);
    access(1'b1, 8'h20, 32'h0000_0100);
    @(negedge clk);
    m1 = '0;
    read_counts("R5 lvl1 clear only");

    // Status word sweep (R8)
    for (int f = 0; f < 64; f++) begin
      err_flags_i = 6'(f);
      temp_i = 12'((f * 613 + 7) % 4096);
      access(1'b0, 8'h00, 32'h0);
      check(r_data == {temp_i, 14'h0, err_flags_i}, "R8 status word", r_data, {temp_i, 14'h0, err_flags_i});
    end

    // Information store (R9)
    access(1'b0, 8'h40, 32'h0); check(r_data == BT, "R9 info 0x40", r_data, BT);
    access(1'b0, 8'h41, 32'h0); check(r_data == {16'h0, VER}, "R9 info 0x41", r_data, {16'h0, VER});
    access(1'b0, 8'h42, 32'h0); check(r_data == HW, "R9 info 0x42", r_data, HW);
    access(1'b0, 8'h43, 32'h0); check(r_data == 32'h0, "R9 info 0x43", r_data, 0);

    // Full address decode sweep (R10)
    for (int a = 0; a < 256; a++) begin
      access(1'b0, 8'(a), 32'h0);
      check(r_resp == exp_resp(1'b0, 8'(a)), "R10 read decode", 32'(r_resp), 32'(exp_resp(1'b0, 8'(a))));
      if (exp_resp(1'b0, 8'(a)) == 3'b010)
        check(r_data == 32'h0, "R10 unknown data", r_data, 0);
    end
    @(negedge clk);
    check({bus_ack, bus_unknown, bus_err} == 3'b000, "R10 idle quiet", 32'({bus_ack, bus_unknown, bus_err}), 0);

    // Refused and unknown writes change nothing (R10)
    access(1'b1, 8'h01, 32'hFFFF_FFFF);
    check(r_resp == 3'b001, "R10 ro write err", 32'(r_resp), 1);
    read_counts("R10 counters kept");
    access(1'b1, 8'h42, 32'h1111_2222);
    check(r_resp == 3'b001, "R10 info write err", 32'(r_resp), 1);
    access(1'b0, 8'h42, 32'h0);
    check(r_data == HW, "R10 info kept", r_data, HW);
    access(1'b1, 8'h23, 32'hDEAD_BEEF);
    check(r_resp == 3'b010, "R10 unknown write", 32'(r_resp), 2);
    check(ctrl1_o == 32'h0000_0100 && ctrl2_o == 32'h0F0F_7777, "R10 ctrl kept", ctrl1_o, 32'h0000_0100);
    check(r_pulse == 22'h0, "R10 no pulse", 32'(r_pulse), 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule